// File: doc/BRIEF.md
# I2S Master Serializer with Bit-Clock Generation

This block is the master side of a stereo serial audio link. It divides a source clock down to a bit clock, frames the bit stream into left and right slots with a word-select line, shifts transmit samples out onto a serial data pin and assembles bits from a serial data input into received words. Toward the transmit and receive FIFOs it trades whole 32-bit transfer words through valid/ready handshakes. Inside a transfer word the sample is always packed against the most significant end. A 20-bit sample therefore sits 12 places up and a 24-bit sample sits 8 places up.

Slot length and sample length are set independently, each as its value minus one. A placement control puts the sample either at the start of its slot or at the end of it. Unused slot bits go out as zeros. A timing control selects between delayed-MSB framing and justified framing. A mono control keeps only the left slot active. The configuration is static: it may change only while the global enable is low. Raising the global enable starts the bit clock. Transmit and receive each have their own enable. When no transmit word is available the slot is filled with zeros, and the clock keeps running.

Top module: `i2s_master_serdes`

## Requirements
- R1: While `en` is high, `sck` changes level once every `cfg_div`+1 source clock cycles, so its period is 2×(`cfg_div`+1) cycles. The first edge after `en` rises is a falling edge.
- R2: A frame is a left slot followed by a right slot. Each slot is W = `cfg_word_m1`+1 bit clocks long, and a field value of 0 gives a 1-bit slot. In justified mode (`cfg_justified`=1), `ws` is low for every bit of the left slot and high for every bit of the right slot.
- R3: In delayed mode (`cfg_justified`=0), `ws` takes the level of the next slot (low = left, high = right) during the last bit of the current slot. The MSB therefore follows the `ws` change by one bit clock.
- R4: `sd_out` changes only after a falling `sck` edge. `sd_in` is sampled on the rising `sck` edge.
- R5: The sample length is S = `cfg_sample_m1`+1. When `cfg_sample_m1` is 0, or S would exceed W, then S = W. A slot sends bits 31, 30, … down to 32−S of its transfer word, MSB first.
- R6: With `cfg_tail_place`=0 the S sample bits occupy the first S bit clocks of the slot. With `cfg_tail_place`=1 they occupy the last S bit clocks. All other slot bits are 0.
- R7: `tx_ready` pulses for one cycle at the start of each active slot while `tx_en` is high, and a word is taken when `tx_valid` is also high. If `tx_valid` is low, the slot sends zeros. If `tx_en` is low, `sd_out` stays 0 and `tx_ready` never rises.
- R8: With `cfg_mono`=1 only the left slot is active. It takes one word per frame, the right slot sends zeros, and bits arriving in the right slot are not collected.
- R9: After the last bit of each active slot, `rx_data` holds the S received bits at bits 31 down to 32−S, with zeros below, and `rx_valid` rises. `rx_valid` stays high until a cycle with `rx_ready` high. If a new word completes in that same cycle, the new word replaces the old one and `rx_valid` stays high.
- R10: While `rx_en` is low, `rx_valid` does not rise.
- R11: While `en` is low (and after reset), `sck` is high, `ws` and `sd_out` are low, `tx_ready` and `rx_valid` are low, and framing restarts from the left slot when `en` is next raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Bit-clock divider value |
| cfg_word_m1 | input | 5 | Slot length minus one |
| cfg_sample_m1 | input | 5 | Sample length minus one (0 = slot length) |
| cfg_justified | input | 1 | 1 = justified framing, 0 = delayed-MSB framing |
| cfg_mono | input | 1 | 1 = left slot only |
| cfg_tail_place | input | 1 | 1 = sample at end of slot, 0 = at start |
| en | input | 1 | Global enable; starts the bit clock |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select (low = left slot) |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| tx_data | input | 32 | Transmit transfer word, sample left-aligned |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 32 | Received transfer word, sample left-aligned |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Consumer takes the pending word |

## Verification
Two events can meet in one cycle: the consumer accepts a pending received word, and the next received word completes on that same rising bit-clock edge. The bench holds `rx_ready` low until one word is pending. It then counts rising `sck` edges at the pins, with `sd_out` looped back to `sd_in`, and raises `rx_ready` for exactly the cycle in which the second slot's last bit is sampled. The result passes only if `rx_valid` is still high afterwards and `rx_data` equals the second slot's sample. A lost word or a retained old word fails the check, and one further accept cycle must then clear `rx_valid`.

// File: rtl/i2sm_pkg.sv
package i2sm_pkg;
  localparam int XFER_W = 32;
  localparam int LEN_W  = $clog2(XFER_W);
  localparam int CNT_W  = LEN_W + 1;

  function automatic logic [CNT_W-1:0] slot_bits(input logic [LEN_W-1:0] word_m1);
    return {1'b0, word_m1} + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] sample_bits(input logic [LEN_W-1:0] word_m1,
                                                   input logic [LEN_W-1:0] sample_m1);
    if (sample_m1 == '0 || sample_m1 > word_m1) return slot_bits(word_m1);
    return {1'b0, sample_m1} + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] sample_start(input logic [CNT_W-1:0] slot,
                                                    input logic [CNT_W-1:0] smp,
                                                    input logic tail);
    return tail ? slot - smp : '0;
  endfunction

  function automatic logic in_sample(input logic [LEN_W-1:0] pos,
                                     input logic [CNT_W-1:0] start,
                                     input logic [CNT_W-1:0] len);
    return ({1'b0, pos} >= start) && ({1'b0, pos} < start + len);
  endfunction

  function automatic logic [XFER_W-1:0] left_align(input logic [XFER_W-1:0] v,
                                                   input logic [CNT_W-1:0] len);
    return v << (CNT_W'(XFER_W) - len);
  endfunction

  function automatic logic ws_level(input logic ch, input logic [LEN_W-1:0] pos,
                                    input logic [CNT_W-1:0] slot, input logic justified);
    if (justified) return ch;
    return ({1'b0, pos} == slot - CNT_W'(1)) ? ~ch : ch;
  endfunction
endpackage

// File: rtl/i2sm_bitclk.sv
module i2sm_bitclk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             fall_evt,
  output logic             rise_evt
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = en && (cnt == div);
  assign fall_evt = tick && sck;
  assign rise_evt = tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!en) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: bit clock parks high whenever the block is disabled
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> sck);
endmodule

// File: rtl/i2sm_framer.sv
module i2sm_framer
  import i2sm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] slot_len,
  output logic [LEN_W-1:0] pos,
  output logic             ch,
  output logic             run,
  output logic [LEN_W-1:0] nxt_pos,
  output logic             nxt_ch
);
  logic last;

  assign last    = ({1'b0, pos} >= slot_len - CNT_W'(1));
  assign nxt_pos = last ? '0 : pos + 1'b1;
  assign nxt_ch  = last ? ~ch : ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      ch  <= 1'b1;
      run <= 1'b0;
    end else if (!en) begin
      pos <= LEN_W'(slot_len - CNT_W'(1));
      ch  <= 1'b1;
      run <= 1'b0;
    end else if (fall_evt) begin
      pos <= nxt_pos;
      ch  <= nxt_ch;
      run <= 1'b1;
    end
  end

  // R2: the bit position never leaves the programmed slot
  assert_pos_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && run |-> ({1'b0, pos} < slot_len));
endmodule

// File: rtl/i2sm_txser.sv
module i2sm_txser
  import i2sm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_en,
  input  logic              load_evt,
  input  logic [XFER_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              bit_on,
  input  logic [LEN_W-1:0]  bit_idx,
  output logic              tx_ready,
  output logic              sd
);
  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(XFER_W - 1);
  logic [XFER_W-1:0] word;

  assign tx_ready = load_evt && tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (!en)      word <= '0;
    else if (load_evt) word <= (tx_en && tx_valid) ? tx_data : '0;
  end

  assign sd = en && tx_en && bit_on && word[TOP_IDX - bit_idx];

  // R7: a slot begun without a valid word is filled with zeros
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && load_evt && !tx_valid |=> !sd);
endmodule

// File: rtl/i2sm_rxdes.sv
module i2sm_rxdes
  import i2sm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_en,
  input  logic              rise_evt,
  input  logic              bit_on,
  input  logic              slot_end,
  input  logic [CNT_W-1:0]  smp_len,
  input  logic              sd_in,
  input  logic              rx_ready,
  output logic [XFER_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [XFER_W-1:0] acc, acc_nx;
  logic              done;

  assign acc_nx = (rise_evt && bit_on) ? {acc[XFER_W-2:0], sd_in} : acc;
  assign done   = rise_evt && slot_end && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (!en) begin
      acc      <= '0;
      rx_valid <= 1'b0;
    end else begin
      acc <= acc_nx;
      if (done) begin
        rx_data  <= left_align(acc_nx, smp_len);
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R9: a pending word is held until taken
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_valid && !rx_ready |=> rx_valid);
  // R10: receive disabled produces no new word
  assert_rx_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en && !rx_en && !rx_valid |=> !rx_valid);
endmodule

// File: rtl/i2s_master_serdes.sv
module i2s_master_serdes
  import i2sm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_word_m1,
  input  logic [LEN_W-1:0]  cfg_sample_m1,
  input  logic              cfg_justified,
  input  logic              cfg_mono,
  input  logic              cfg_tail_place,
  input  logic              en,
  input  logic              tx_en,
  input  logic              rx_en,
  output logic              sck,
  output logic              ws,
  output logic              sd_out,
  input  logic              sd_in,
  input  logic [XFER_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [XFER_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  logic             fall_evt, rise_evt, ch, nxt_ch, run;
  logic [LEN_W-1:0] pos, nxt_pos, bit_idx;
  logic [CNT_W-1:0] slen, smp, start;
  logic             active, bit_on, slot_end, load_evt;

  assign slen     = slot_bits(cfg_word_m1);
  assign smp      = sample_bits(cfg_word_m1, cfg_sample_m1);
  assign start    = sample_start(slen, smp, cfg_tail_place);
  assign active   = !cfg_mono || !ch;
  assign bit_on   = active && in_sample(pos, start, smp);
  assign bit_idx  = pos - start[LEN_W-1:0];
  assign slot_end = active && ({1'b0, pos} == slen - CNT_W'(1));
  assign load_evt = fall_evt && (nxt_pos == '0) && (!cfg_mono || !nxt_ch);
  assign ws       = en && run && ws_level(ch, pos, slen, cfg_justified);

  i2sm_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .en(en), .div(cfg_div),
    .sck(sck), .fall_evt(fall_evt), .rise_evt(rise_evt));

  i2sm_framer u_framer (
    .clk(clk), .rst_n(rst_n), .en(en), .fall_evt(fall_evt), .slot_len(slen),
    .pos(pos), .ch(ch), .run(run), .nxt_pos(nxt_pos), .nxt_ch(nxt_ch));

  i2sm_txser u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_en(tx_en), .load_evt(load_evt),
    .tx_data(tx_data), .tx_valid(tx_valid), .bit_on(bit_on), .bit_idx(bit_idx),
    .tx_ready(tx_ready), .sd(sd_out));

  i2sm_rxdes u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_en(rx_en), .rise_evt(rise_evt),
    .bit_on(bit_on), .slot_end(slot_end), .smp_len(smp), .sd_in(sd_in),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid));

  // R3: delayed framing moves ws as the last bit of a slot begins
  assert_ws_delayed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && run && $past(run) && !cfg_justified && $stable(cfg_justified)
    && !$stable(ws) |-> ({1'b0, pos} == slen - CNT_W'(1)));
  // R2: justified framing moves ws together with the first bit of a slot
  assert_ws_justified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && run && $past(run) && cfg_justified && $stable(cfg_justified)
    && !$stable(ws) |-> (pos == '0));
  // R4: serial data moves only after a falling bit-clock edge
  assert_sd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && $stable(tx_en) && !$stable(sd_out) |-> $past(fall_evt));
  // R8: the right slot stays silent in mono framing
  assert_mono_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && cfg_mono && ch |-> !sd_out);
  // R7: words are requested only at a falling bit-clock edge
  assert_ready_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> fall_evt);
  // R11: no handshake while disabled
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_ready && !ws && !sd_out);
endmodule

// File: tb/test_i2s_master_serdes.sv
`timescale 1ns/1ps
module test_i2s_master_serdes;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_div = '0;
  logic [4:0]  cfg_word_m1 = '0, cfg_sample_m1 = '0;
  logic        cfg_justified = 1'b0, cfg_mono = 1'b0, cfg_tail_place = 1'b0;
  logic        en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic        sck, ws, sd_out, sd_in;
  logic [31:0] tx_data, rx_data;
  logic        tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;

  assign sd_in = sd_out;

  i2s_master_serdes i_i2s_master_serdes (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_word_m1(cfg_word_m1),
    .cfg_sample_m1(cfg_sample_m1), .cfg_justified(cfg_justified), .cfg_mono(cfg_mono),
    .cfg_tail_place(cfg_tail_place), .en(en), .tx_en(tx_en), .rx_en(rx_en),
    .sck(sck), .ws(ws), .sd_out(sd_out), .sd_in(sd_in), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready));

  always #2.5 clk = ~clk;

  // {div[3:0], word_m1[4:0], sample_m1[4:0], justified, mono, tail}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 5'd15, 5'd0,  1'b0, 1'b0, 1'b0},
    {4'd0, 5'd31, 5'd23, 1'b1, 1'b0, 1'b0},
    {4'd2, 5'd23, 5'd19, 1'b0, 1'b0, 1'b1},
    {4'd1, 5'd15, 5'd31, 1'b1, 1'b1, 1'b1},
    {4'd3, 5'd7,  5'd4,  1'b0, 1'b1, 1'b0},
    {4'd0, 5'd0,  5'd0,  1'b1, 1'b0, 1'b0},
    {4'd0, 5'd31, 5'd0,  1'b0, 1'b0, 1'b0}
  };

  int n_chk = 0, n_bad = 0;
  int n_rise, n_tx, n_rx, n_ready, gap;
  bit hs_pend, seen, sd_seen, rxv_seen, prev_sck = 1'b1, done_flag = 1'b0;
  bit cap_ws [256];
  bit cap_sd [256];
  logic [31:0] rx_words [16];

  function automatic logic [31:0] pat(input int n);
    return (32'h9E3779B9 * 32'(n + 1)) ^ 32'h5A5A0F0F;
  endfunction

  function automatic int smp_len(input int w_m1, input int s_m1);
    if (s_m1 == 0 || s_m1 > w_m1) return w_m1 + 1;
    return s_m1 + 1;
  endfunction

  assign tx_data = pat(n_tx);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (en) begin
      gap++;
      if (sck != prev_sck) begin
        if (seen) check(gap == int'(cfg_div) + 1, "R1", gap, int'(cfg_div) + 1);
        seen = 1'b1;
        gap = 0;
        if (sck && n_rise < 256) begin
          cap_ws[n_rise] = ws;
          cap_sd[n_rise] = sd_out;
          n_rise++;
        end
      end
      if (hs_pend) n_tx++;
      hs_pend = tx_ready && tx_valid;
      if (tx_ready) n_ready++;
      if (sd_out) sd_seen = 1'b1;
      if (rx_valid) rxv_seen = 1'b1;
      if (rx_valid && rx_ready && n_rx < 16) begin
        rx_words[n_rx] = rx_data;
        n_rx++;
      end
    end
    prev_sck = sck;
  end

  task automatic clear_mon();
    n_rise = 0; n_tx = 0; n_rx = 0; n_ready = 0; gap = 0;
    hs_pend = 0; seen = 0; sd_seen = 0; rxv_seen = 0;
  endtask

  task automatic apply_cfg(input logic [16:0] v);
    cfg_div = 16'(v[16:13]); cfg_word_m1 = v[12:8]; cfg_sample_m1 = v[7:3];
    cfg_justified = v[2]; cfg_mono = v[1]; cfg_tail_place = v[0];
  endtask

  task automatic run_rises(input int target);
    @(posedge clk); #1;
    en = 1'b1;
    do begin @(posedge clk); #1; end while (n_rise < target);
    en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic run_vec(input int vi);
    int w, s, off, tot, nexp;
    apply_cfg(VEC[vi]);
    tx_en = 1; rx_en = 1; rx_ready = 1; tx_valid = 1;
    clear_mon();
    w = int'(cfg_word_m1) + 1;
    s = smp_len(cfg_word_m1, cfg_sample_m1);
    off = cfg_tail_place ? w - s : 0;
    tot = 6 * w;
    run_rises(tot);
    for (int k = 0; k < tot; k++) begin
      int j, p, widx;
      bit e_ws, e_sd, act;
      logic [31:0] wd;
      j = k / w; p = k % w;
      act = !cfg_mono || (j % 2 == 0);
      widx = cfg_mono ? j / 2 : j;
      e_ws = cfg_justified ? bit'(j % 2) : bit'(((k + 1) / w) % 2);
      wd = pat(widx);
      e_sd = act && p >= off && p < off + s ? wd[31 - (p - off)] : 1'b0;
      check(cap_ws[k] == e_ws, cfg_justified ? "R2" : "R3", 32'(cap_ws[k]), 32'(e_ws));
      check(cap_sd[k] == e_sd, cfg_mono ? "R8" : (cfg_tail_place ? "R6" : "R5"),
            32'(cap_sd[k]), 32'(e_sd));
    end
    nexp = cfg_mono ? 3 : 6;
    check(n_rx == nexp, "R9", n_rx, nexp);
    for (int i = 0; i < nexp && i < n_rx; i++)
      check(rx_words[i] == (pat(i) & ~(32'hFFFF_FFFF >> s)), "R9", rx_words[i],
            pat(i) & ~(32'hFFFF_FFFF >> s));
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11: reset and disabled state
    check(sck == 1'b1, "R11", 32'(sck), 1);
    check(ws == 1'b0 && sd_out == 1'b0, "R11", {ws, sd_out}, 0);
    check(tx_ready == 1'b0 && rx_valid == 1'b0, "R11", {tx_ready, rx_valid}, 0);
    check(rx_data == '0, "R11", rx_data, 0);

    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // R7: transmit disabled keeps the data line low and requests nothing
    apply_cfg(VEC[0]); clear_mon();
    tx_en = 0; tx_valid = 1; rx_en = 1; rx_ready = 1;
    run_rises(64);
    check(sd_seen == 1'b0, "R7", 32'(sd_seen), 0);
    check(n_ready == 0, "R7", n_ready, 0);

    // R7: no word offered sends zeros but still requests per slot
    clear_mon(); tx_en = 1; tx_valid = 0;
    run_rises(64);
    check(sd_seen == 1'b0, "R7", 32'(sd_seen), 0);
    check(n_ready == 4, "R7", n_ready, 4);

    // R10: receive disabled yields no word
    clear_mon(); tx_valid = 1; rx_en = 0;
    run_rises(64);
    check(rxv_seen == 1'b0, "R10", 32'(rxv_seen), 0);

    // R9: accept coinciding with the next completion
    clear_mon(); rx_en = 1; rx_ready = 0;
    @(posedge clk); #1 en = 1'b1;
    do begin @(posedge clk); #1; end while (n_rise < 31);
    check(rx_valid == 1'b1, "R9", 32'(rx_valid), 1);
    check(rx_data == (pat(0) & 32'hFFFF_0000), "R9", rx_data, pat(0) & 32'hFFFF_0000);
    @(posedge clk); @(posedge clk); #1 rx_ready = 1;
    @(posedge clk); #1 rx_ready = 0;
    check(rx_valid == 1'b1, "R9", 32'(rx_valid), 1);
    check(rx_data == (pat(1) & 32'hFFFF_0000), "R9", rx_data, pat(1) & 32'hFFFF_0000);
    rx_ready = 1;
    @(posedge clk); #1 rx_ready = 0;
    check(rx_valid == 1'b0, "R9", 32'(rx_valid), 0);
    en = 1'b0;
    @(posedge clk); #1;
    // R11: disabling returns the pins to idle
    check(sck == 1'b1 && ws == 1'b0 && sd_out == 1'b0, "R11", {sck, ws, sd_out}, 3'b100);
    check(tx_ready == 1'b0 && rx_valid == 1'b0, "R11", {tx_ready, rx_valid}, 0);
    report();
  end
endmodule